// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block parks a set of general-purpose IO bank channels in a safe, frozen state and later returns them to normal use. It does this by moving five pad protection controls per channel through a fixed series of steps. Three controls are active low: slew enable, weak pull-up and tristate. Bus-hold is also active low. The fifth, configuration-done, is active high. Between two steps the block always waits a minimum gap, counted in system clock cycles. The gap is derived at elaboration from a time in nanoseconds and the clock period, rounded up.

Software requests a freeze or a thaw with a one-cycle pulse. A source-select input must choose software-controlled sequencing, or the pulse is not taken. Once a request is accepted, the block visits the channels one after another in ascending order. A busy output covers the whole sequence. Each channel's frozen flag changes only when that channel's last step is applied. After reset every channel is frozen.

Top module: `io_freeze_seq`

## Requirements
- R1: While reset is held and right after it, every channel has slew_n, pullup_n, tristate_n, bushold_n and cfg_done all at 0, every frozen flag is 1, and busy is 0.
- R2: A freeze takes two steps per channel. The first step drives slew_n, pullup_n and tristate_n of that channel to 0 in the same cycle. The second step drives bushold_n and cfg_done of that channel to 0.
- R3: A thaw takes three steps per channel. Step one drives bushold_n and cfg_done to 1. Step two drives pullup_n and tristate_n to 1 together. Step three drives slew_n to 1.
- R4: The first step is applied on the clock edge after the one that accepts the request. Each later step follows the previous one by exactly GAP_CYC cycles, where GAP_CYC = ceil(GAP_NS*1000 / CLK_PERIOD_PS), and never less than 1.
- R5: Channels are processed in ascending index order. The first step of channel c+1 comes GAP_CYC cycles after the last step of channel c.
- R6: A channel's frozen flag changes on the same clock edge as that channel's final step, and never earlier. It becomes 1 after a freeze and 0 after a thaw.
- R7: busy rises on the edge that accepts a request. It falls on the edge that applies the final step of the last channel.
- R8: A freeze or thaw request that arrives while busy is 1 is ignored. The running sequence continues unchanged.
- R9: Requests are accepted only when sw_sel is 1. With sw_sel at 0, pulses have no effect: busy stays 0 and all outputs hold.
- R10: If freeze_req and thaw_req are high in the same cycle, the request is treated as a freeze.
- R11: A thaw of channels that are already thawed runs its full step count and timing but leaves every pad control and flag unchanged. The same holds for a freeze of frozen channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_sel | input | 1 | 1 = software-controlled sequencing accepts requests |
| freeze_req | input | 1 | One-cycle freeze request pulse |
| thaw_req | input | 1 | One-cycle thaw request pulse |
| slew_n | output | NUM_CH | Per-channel slew enable, active low |
| pullup_n | output | NUM_CH | Per-channel weak pull-up, active low |
| tristate_n | output | NUM_CH | Per-channel tristate, active low |
| bushold_n | output | NUM_CH | Per-channel bus-hold, active low |
| cfg_done | output | NUM_CH | Per-channel configuration done, active high |
| frozen | output | NUM_CH | Per-channel status, 1 = frozen |
| busy | output | 1 | High while a sequence runs |

## Verification
The assertions run on every cycle and check the following:
- No pad control moves while the block is idle.
- Within one sequence, two output changes are never closer than the gap.
- No channel ever has bus-hold engaged while any of its three first-level controls is released.
- Whenever a frozen flag rises or falls, all five controls of that channel already sit at the matching level.

The exact cycle of each step is shown only by the bench scenarios, which compare every cycle against an arithmetic model. The same goes for the ascending channel order, the request priority, ignoring requests while busy or in hardware mode, and the no-change thaw of thawed channels.

// File: rtl/frz_pkg.sv
// Shared types and constants for the IO freeze sequencer.
package frz_pkg;

    typedef enum logic {
        OP_FREEZE = 1'b0,
        OP_THAW   = 1'b1
    } frz_op_e;

    // Pad protection controls of one channel
    typedef struct packed {
        logic slew_n;
        logic pullup_n;
        logic tristate_n;
        logic bushold_n;
        logic cfg_done;
    } pad_ctl_t;

    localparam int FREEZE_STEPS = 2;
    localparam int THAW_STEPS   = 3;
    localparam int STEP_W       = 2;

endpackage

// File: rtl/frz_gap_timer.sv
// Gap timer: after a load it counts GAP_CYC-1 cycles down to zero.
// Assumes it is loaded only while zero is high.
module frz_gap_timer #(
    parameter int GAP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Reload on a step, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/frz_seq_fsm.sv
// Sequence control: accepts a request, then walks the channels in
// ascending order and issues one step strobe each time the gap expires.
// Assumes the gap timer reads zero while idle.
module frz_seq_fsm
    import frz_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_sel,
    input  logic              freeze_req,
    input  logic              thaw_req,
    input  logic              gap_zero,
    output logic              busy,
    output frz_op_e           op,
    output logic              step_en,
    output logic [CH_W-1:0]   step_ch,
    output logic [STEP_W-1:0] step_idx,
    output logic              gap_load
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic              busy_q;
    frz_op_e           op_q;
    logic [CH_W-1:0]   ch_q;
    logic [STEP_W-1:0] idx_q;
    logic              accept;
    logic              last_idx;
    logic              last_step;

    // Acceptance: idle, software mode, any request; freeze has priority
    always_comb begin
        accept    = !busy_q && sw_sel && (freeze_req || thaw_req);
        last_idx  = (op_q == OP_FREEZE) ? (idx_q == STEP_W'(FREEZE_STEPS - 1))
                                        : (idx_q == STEP_W'(THAW_STEPS - 1));
        last_step = last_idx && (ch_q == LAST_CH);
        step_en   = busy_q && gap_zero;
        gap_load  = step_en && !last_step;
    end

    // Sequence state: operation, channel and step position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            op_q   <= OP_FREEZE;
            ch_q   <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            op_q   <= freeze_req ? OP_FREEZE : OP_THAW;
            ch_q   <= '0;
            idx_q  <= '0;
        end else if (step_en) begin
            if (last_step) begin
                busy_q <= 1'b0;
            end else if (last_idx) begin
                ch_q  <= ch_q + 1'b1;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy     = busy_q;
    assign op       = op_q;
    assign step_ch  = ch_q;
    assign step_idx = idx_q;
endmodule

// File: rtl/frz_chan_regs.sv
// One channel's pad control register and frozen flag. Applies the step
// named by the sequencer when the strobe addresses this channel.
// Resets to the frozen state.
module frz_chan_regs
    import frz_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  frz_op_e           op,
    input  logic [STEP_W-1:0] step_idx,
    output pad_ctl_t          ctl,
    output logic              frozen
);
    pad_ctl_t ctl_q;
    logic     frz_q;

    // Step application; the flag moves with the final step only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            frz_q <= 1'b1;
        end else if (hit) begin
            if (op == OP_FREEZE) begin
                case (step_idx)
                    2'd0: begin
                        ctl_q.slew_n     <= 1'b0;
                        ctl_q.pullup_n   <= 1'b0;
                        ctl_q.tristate_n <= 1'b0;
                    end
                    default: begin
                        ctl_q.bushold_n  <= 1'b0;
                        ctl_q.cfg_done   <= 1'b0;
                        frz_q            <= 1'b1;
                    end
                endcase
            end else begin
                case (step_idx)
                    2'd0: begin
                        ctl_q.bushold_n  <= 1'b1;
                        ctl_q.cfg_done   <= 1'b1;
                    end
                    2'd1: begin
                        ctl_q.pullup_n   <= 1'b1;
                        ctl_q.tristate_n <= 1'b1;
                    end
                    default: begin
                        ctl_q.slew_n     <= 1'b1;
                        frz_q            <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign ctl    = ctl_q;
    assign frozen = frz_q;
endmodule

// File: rtl/io_freeze_seq.sv
// Top of the IO freeze sequencer: one sequencer, one gap timer and one
// register slice per channel. GAP_CYC is the minimum step spacing,
// rounded up from GAP_NS at clock period CLK_PERIOD_PS.
module io_freeze_seq
    import frz_pkg::*;
#(
    parameter int NUM_CH        = 3,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int GAP_NS        = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_sel,
    input  logic              freeze_req,
    input  logic              thaw_req,
    output logic [NUM_CH-1:0] slew_n,
    output logic [NUM_CH-1:0] pullup_n,
    output logic [NUM_CH-1:0] tristate_n,
    output logic [NUM_CH-1:0] bushold_n,
    output logic [NUM_CH-1:0] cfg_done,
    output logic [NUM_CH-1:0] frozen,
    output logic              busy
);
    localparam int GAP_RAW = (GAP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              gap_zero;
    logic              gap_load;
    logic              step_en;
    frz_op_e           op;
    logic [CH_W-1:0]   step_ch;
    logic [STEP_W-1:0] step_idx;

    frz_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .zero  (gap_zero)
    );

    frz_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_sel     (sw_sel),
        .freeze_req (freeze_req),
        .thaw_req   (thaw_req),
        .gap_zero   (gap_zero),
        .busy       (busy),
        .op         (op),
        .step_en    (step_en),
        .step_ch    (step_ch),
        .step_idx   (step_idx),
        .gap_load   (gap_load)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pad_ctl_t ctl;

        frz_chan_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (step_en && (step_ch == CH_W'(c))),
            .op       (op),
            .step_idx (step_idx),
            .ctl      (ctl),
            .frozen   (frozen[c])
        );

        assign slew_n[c]     = ctl.slew_n;
        assign pullup_n[c]   = ctl.pullup_n;
        assign tristate_n[c] = ctl.tristate_n;
        assign bushold_n[c]  = ctl.bushold_n;
        assign cfg_done[c]   = ctl.cfg_done;
    end
endmodule

// File: rtl/io_freeze_seq_chk.sv
// Property checker for io_freeze_seq, attached by bind.
// Watches only the top-level ports.
module io_freeze_seq_chk #(
    parameter int NUM_CH  = 3,
    parameter int GAP_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] slew_n,
    input logic [NUM_CH-1:0] pullup_n,
    input logic [NUM_CH-1:0] tristate_n,
    input logic [NUM_CH-1:0] bushold_n,
    input logic [NUM_CH-1:0] cfg_done,
    input logic [NUM_CH-1:0] frozen,
    input logic              busy
);
    localparam int OW = 5 * NUM_CH;

    logic [OW-1:0] outs;
    logic [OW-1:0] outs_q;
    logic          changed;
    logic          busy_q;
    logic          seen_q;
    int unsigned   since_q;

    assign outs    = {slew_n, pullup_n, tristate_n, bushold_n, cfg_done};
    assign changed = (outs != outs_q);

    // Track cycles since the last output change inside a sequence
    always_ff @(posedge clk) begin
        outs_q <= outs;
        busy_q <= busy;
        if (!rst_n) begin
            seen_q  <= 1'b0;
            since_q <= 0;
        end else begin
            if (busy && !busy_q)
                seen_q <= 1'b0;
            else if (changed)
                seen_q <= 1'b1;
            if (changed)
                since_q <= 1;
            else if (since_q < GAP_CYC)
                since_q <= since_q + 1;
        end
    end

    // R9/R8: pad controls hold while idle
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(outs));

    // R4: steps within one sequence are at least the gap apart
    p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (changed && seen_q && !(busy && !busy_q)) |-> (since_q >= GAP_CYC));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pc
        // R2/R3: bus-hold engaged only with the first-level controls engaged
        p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !bushold_n[c] |-> (!slew_n[c] && !pullup_n[c] && !tristate_n[c]));

        // R3: pull-up and tristate always move together
        p_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pullup_n[c] == tristate_n[c]);

        // R6: flag set only with all five controls frozen
        p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(frozen[c]) |-> (!slew_n[c] && !pullup_n[c] && !tristate_n[c]
                                  && !bushold_n[c] && !cfg_done[c]));

        // R6: flag cleared only with all five controls released
        p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(frozen[c]) |-> (slew_n[c] && pullup_n[c] && tristate_n[c]
                                  && bushold_n[c] && cfg_done[c]));
    end
endmodule

bind io_freeze_seq io_freeze_seq_chk #(
    .NUM_CH  (NUM_CH),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slew_n     (slew_n),
    .pullup_n   (pullup_n),
    .tristate_n (tristate_n),
    .bushold_n  (bushold_n),
    .cfg_done   (cfg_done),
    .frozen     (frozen),
    .busy       (busy)
);

// File: tb/tb_io_freeze_seq.sv
// Bench: each sequence is compared cycle by cycle against an arithmetic
// model of the step schedule.
module tb_io_freeze_seq;
    localparam int NCH  = 3;
    localparam int PER  = 4000;
    localparam int GNS  = 20;
    localparam int G    = (GNS * 1000 + PER - 1) / PER;

    logic clk = 1'b0;
    logic rst_n, sw_sel, freeze_req, thaw_req;
    logic [NCH-1:0] slew_n, pullup_n, tristate_n, bushold_n, cfg_done, frozen;
    logic busy;

    int checks = 0;
    int errors = 0;

    logic [NCH-1:0] m_slew, m_pu, m_tri, m_bh, m_cfg, m_frz;

    always #2ns clk = ~clk;

    io_freeze_seq #(.NUM_CH(NCH), .CLK_PERIOD_PS(PER), .GAP_NS(GNS)) dut (
        .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel),
        .freeze_req(freeze_req), .thaw_req(thaw_req),
        .slew_n(slew_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
        .bushold_n(bushold_n), .cfg_done(cfg_done), .frozen(frozen),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ctl_vec();
        return {17'd0, slew_n, pullup_n, tristate_n, bushold_n, cfg_done};
    endfunction

    function automatic logic [31:0] mdl_vec();
        return {17'd0, m_slew, m_pu, m_tri, m_bh, m_cfg};
    endfunction

    // Apply global step s of a freeze (2 per channel) or thaw (3 per channel)
    task automatic apply_step(input bit frz, input int s);
        int spc = frz ? 2 : 3;
        int ch  = s / spc;
        int k   = s % spc;
        if (frz) begin
            if (k == 0) begin m_slew[ch] = 0; m_pu[ch] = 0; m_tri[ch] = 0; end
            else begin m_bh[ch] = 0; m_cfg[ch] = 0; m_frz[ch] = 1; end
        end else begin
            if (k == 0) begin m_bh[ch] = 1; m_cfg[ch] = 1; end
            else if (k == 1) begin m_pu[ch] = 1; m_tri[ch] = 1; end
            else begin m_slew[ch] = 1; m_frz[ch] = 0; end
        end
    endtask

    task automatic compare_all(input bit frz, input logic exp_busy);
        check(busy == exp_busy, "R7 busy", busy, exp_busy);
        check(ctl_vec() == mdl_vec(), frz ? "R2/R4/R5 freeze controls"
                                          : "R3/R4/R5 thaw controls",
              ctl_vec(), mdl_vec());
        check(frozen == m_frz, "R6 flag", frozen, m_frz);
    endtask

    // One sequence; optionally both requests at once and a stray request mid-run
    task automatic run_seq(input bit frz, input bit both, input bit inject);
        int total = frz ? 2 * NCH : 3 * NCH;
        int done  = 0;
        int last_edge = 1 + (total - 1) * G;
        @(negedge clk);
        freeze_req = frz | both;
        thaw_req   = !frz | both;
        @(posedge clk);
        @(negedge clk);
        freeze_req = 0; thaw_req = 0;
        compare_all(frz, 1'b1);
        for (int k = 1; k <= last_edge + 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            freeze_req = 0; thaw_req = 0;
            while (done < total && done < (k - 1) / G + 1) begin
                apply_step(frz, done);
                done++;
            end
            compare_all(frz, done < total);
            // R8: a stray opposite request while busy
            if (inject && (k == 7 || k == last_edge - 1)) begin
                freeze_req = !frz;
                thaw_req   = frz;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        rst_n = 0; sw_sel = 1; freeze_req = 0; thaw_req = 0;
        m_slew = '0; m_pu = '0; m_tri = '0; m_bh = '0; m_cfg = '0; m_frz = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: frozen reset state while reset is held
        check(ctl_vec() == 32'd0, "R1 controls", ctl_vec(), 32'd0);
        check(frozen == '1, "R1 flags", frozen, '1);
        check(busy == 1'b0, "R1 busy", busy, 1'b0);
        rst_n = 1;
        @(negedge clk);
        compare_all(1'b1, 1'b0);

        // Thaw from frozen, with stray requests mid-run (R3, R8)
        run_seq(1'b0, 1'b0, 1'b1);
        // R11: thaw again, no change expected
        snap = ctl_vec();
        run_seq(1'b0, 1'b0, 1'b0);
        check(ctl_vec() == snap, "R11 no-change thaw", ctl_vec(), snap);
        // R10: both requests together -> freeze
        run_seq(1'b1, 1'b1, 1'b0);
        // R11: freeze of frozen channels
        run_seq(1'b1, 1'b0, 1'b1);

        // R9: hardware mode ignores requests
        sw_sel = 0;
        snap = ctl_vec();
        @(negedge clk); thaw_req = 1;
        @(negedge clk); thaw_req = 0; freeze_req = 1;
        @(negedge clk); freeze_req = 0;
        for (int i = 0; i < 3 * G; i++) begin
            @(negedge clk);
            check(busy == 1'b0, "R9 busy", busy, 1'b0);
            check(ctl_vec() == snap && frozen == m_frz, "R9 hold", ctl_vec(), snap);
        end
        sw_sel = 1;
        // Software mode again: thaw then freeze
        run_seq(1'b0, 1'b0, 1'b0);
        run_seq(1'b1, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule